// File: doc/BRIEF.md
# Repeated String Operation Controller

This block sequences one block string operation over a run of memory elements. Software or a decoder loads a starting count, a source index, a destination index, an operation kind, a repeat rule, an element size and a direction, then pulses `start`. The controller then issues one element request per iteration to a memory-side agent over a request/acknowledge handshake. It steps the indexes after every acknowledged element and counts the remaining elements down.

For compare and scan operations, the agent returns a zero flag with each acknowledge. The repeat rule can then end the run early, either when the flag shows a mismatch or when it shows a match. The count is tested for zero before every iteration, so a zero starting count performs no element step at all. When the run ends, `done` pulses for one cycle. The final count and indexes stay on the outputs until the next start.

Top module: `strrep_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `req` are 0 and `cnt_out`, `si_out`, `di_out` are 0.
- R2: A start with `cnt_in` = 0 issues no request. It pulses `done`, leaves `cnt_out` at 0 and leaves both indexes at their loaded values.
- R3: With repeat rule 0 (count only), exactly `cnt_in` element requests are issued and `cnt_out` ends at 0. Each acknowledged element lowers `cnt_out` by one.
- R4: With repeat rule 1 (while equal) on a compare or scan, the run ends after the first element acknowledged with `zf_in` = 0, or when the count reaches 0.
- R5: With repeat rule 2 (while not equal) on a compare or scan, the run ends after the first element acknowledged with `zf_in` = 1, or when the count reaches 0.
- R6: Each acknowledged element moves each index it uses by 1 when `word_mode` = 0 and by 2 when `word_mode` = 1. The index goes up when `dir_down` = 0 and down when `dir_down` = 1, wrapping modulo 2^AW. The step also applies to the element that ends a conditional run.
- R7: The operation codes are move = 0, load = 1, store = 2, compare = 3 and scan = 4. Move and compare step both indexes. Load steps only the source index. Store and scan step only the destination index.
- R8: For move, load and store, repeat rules 1 and 2 act as count only, and `zf_in` has no effect.
- R9: A request stays high, with stable `req_si` and `req_di`, until `ack` is sampled. `req_si` and `req_di` carry the index values for that element.
- R10: `done` is high for exactly one cycle at the end of a run, never together with `req`. A `start` while `busy` is ignored.
- R11: `req_op` and `req_word` show the operation code and element size latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| op_kind | input | 3 | Operation code (0 move, 1 load, 2 store, 3 compare, 4 scan) |
| rep_kind | input | 2 | Repeat rule (0 count only, 1 while equal, 2 while not equal) |
| word_mode | input | 1 | 1 selects two-byte elements |
| dir_down | input | 1 | 1 makes indexes decrease |
| cnt_in | input | CW | Starting element count |
| si_in | input | AW | Starting source index |
| di_in | input | AW | Starting destination index |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cnt_out | output | CW | Remaining count |
| si_out | output | AW | Current source index |
| di_out | output | AW | Current destination index |
| req | output | 1 | Element request |
| req_op | output | 3 | Operation code of the request |
| req_word | output | 1 | Element size of the request |
| req_si | output | AW | Source index for this element |
| req_di | output | AW | Destination index for this element |
| ack | input | 1 | Element completed |
| zf_in | input | 1 | Zero flag of a compare or scan element, valid with ack |

## Verification
Runs mix all five operations with all three repeat rules, both element sizes and both directions. Counts range from zero upward, and an early-break flag is placed at a random element or past the end. Conditional compare and scan runs separate breaking on the flag from running out of count. The same flag pattern sent to move, load and store shows whether it is wrongly obeyed. Per-operation index movement shows which index each operation may touch, and random acknowledge delays test that the request is held. A start pulsed mid-run and zero-count runs cover the guard cases.

// File: rtl/strrep_pkg.sv
// Shared codes for the repeated string operation controller.
// Assumes operation and repeat-rule codes are fixed by the decoder feeding the block.
package strrep_pkg;
    localparam logic [2:0] OP_MOVE  = 3'd0;
    localparam logic [2:0] OP_LOAD  = 3'd1;
    localparam logic [2:0] OP_STORE = 3'd2;
    localparam logic [2:0] OP_CMP   = 3'd3;
    localparam logic [2:0] OP_SCAN  = 3'd4;

    localparam logic [1:0] RULE_COUNT = 2'd0;
    localparam logic [1:0] RULE_EQ    = 2'd1;
    localparam logic [1:0] RULE_NE    = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_ISSUE = 2'd2,
        ST_FIN   = 2'd3
    } strrep_state_e;
endpackage

// File: rtl/strrep_decode.sv
// Decodes the latched operation and repeat rule into index-use enables and
// the early-stop decision for the element being acknowledged.
// Assumes zf is only meaningful together with an acknowledge.
module strrep_decode
    import strrep_pkg::*;
(
    input  logic [2:0] op,
    input  logic [1:0] rule,
    input  logic       zf,
    output logic       uses_si,
    output logic       uses_di,
    output logic       stop_now
);
    logic is_compare;
    logic rule_cond;

    // Which indexes the operation walks, and whether the flag may end the run
    always_comb begin
        uses_si    = (op == OP_MOVE) || (op == OP_LOAD) || (op == OP_CMP);
        uses_di    = (op == OP_MOVE) || (op == OP_STORE) || (op == OP_CMP) || (op == OP_SCAN);
        is_compare = (op == OP_CMP) || (op == OP_SCAN);
        rule_cond  = (rule == RULE_EQ) || (rule == RULE_NE);
        stop_now   = is_compare && rule_cond && ((rule == RULE_EQ) ? !zf : zf);
    end
endmodule

// File: rtl/strrep_index.sv
// One index register: loads at start, then steps by the element size in the
// chosen direction each time it is enabled. Wraps modulo 2^AW.
module strrep_index #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          word,
    input  logic          down,
    output logic [AW-1:0] idx
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    logic [AW-1:0] delta;

    // Step size from element width
    always_comb delta = word ? TWO : ONE;

    // Index register update
    always_ff @(posedge clk) begin
        if (!rst_n)     idx <= '0;
        else if (load)  idx <= load_val;
        else if (step)  idx <= down ? (idx - delta) : (idx + delta);
    end
endmodule

// File: rtl/strrep_fsm.sv
// Run sequencer: tests the count before every element, holds a request until
// acknowledged, and ends on zero count or on an early-stop decision.
// Assumes ack is only meaningful while req is high.
module strrep_fsm
    import strrep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cnt_zero,
    input  logic ack,
    input  logic stop_now,
    output logic load,
    output logic advance,
    output logic req,
    output logic done,
    output logic busy
);
    strrep_state_e state;

    // Decoded controls from the current state
    always_comb begin
        load    = (state == ST_IDLE) && start;
        req     = (state == ST_ISSUE);
        advance = req && ack;
        done    = (state == ST_FIN);
        busy    = (state != ST_IDLE);
    end

    // State transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (start) state <= ST_CHECK;
                ST_CHECK: state <= cnt_zero ? ST_FIN : ST_ISSUE;
                ST_ISSUE: if (ack) state <= stop_now ? ST_FIN : ST_CHECK;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/strrep_ctrl.sv
// Top of the repeated string operation controller. Latches the run setup,
// keeps the count and both indexes, and drives one element request per
// iteration. Assumes the memory agent answers every request with one ack.
module strrep_ctrl
    import strrep_pkg::*;
#(
    parameter int CW = 16,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_kind,
    input  logic [1:0]    rep_kind,
    input  logic          word_mode,
    input  logic          dir_down,
    input  logic [CW-1:0] cnt_in,
    input  logic [AW-1:0] si_in,
    input  logic [AW-1:0] di_in,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] cnt_out,
    output logic [AW-1:0] si_out,
    output logic [AW-1:0] di_out,
    output logic          req,
    output logic [2:0]    req_op,
    output logic          req_word,
    output logic [AW-1:0] req_si,
    output logic [AW-1:0] req_di,
    input  logic          ack,
    input  logic          zf_in
);
    logic [1:0] rule_q;
    logic       down_q;
    logic       load, advance, stop_now, uses_si, uses_di;
    logic [CW-1:0] cnt_q;

    // Latch the run setup at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_op   <= OP_MOVE;
            rule_q   <= RULE_COUNT;
            req_word <= 1'b0;
            down_q   <= 1'b0;
        end else if (load) begin
            req_op   <= op_kind;
            rule_q   <= rep_kind;
            req_word <= word_mode;
            down_q   <= dir_down;
        end
    end

    // Remaining element count
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (load)     cnt_q <= cnt_in;
        else if (advance)  cnt_q <= cnt_q - CW'(1);
    end

    strrep_decode u_dec (
        .op(req_op), .rule(rule_q), .zf(zf_in),
        .uses_si(uses_si), .uses_di(uses_di), .stop_now(stop_now)
    );

    strrep_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_zero(cnt_q == '0),
        .ack(ack), .stop_now(stop_now), .load(load), .advance(advance),
        .req(req), .done(done), .busy(busy)
    );

    strrep_index #(.AW(AW)) u_si (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(si_in),
        .step(advance && uses_si), .word(req_word), .down(down_q), .idx(si_out)
    );

    strrep_index #(.AW(AW)) u_di (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(di_in),
        .step(advance && uses_di), .word(req_word), .down(down_q), .idx(di_out)
    );

    // Request addresses are the current indexes
    always_comb begin
        cnt_out = cnt_q;
        req_si  = si_out;
        req_di  = di_out;
    end
endmodule

// File: rtl/strrep_ctrl_chk.sv
// Temporal checks for strrep_ctrl, attached by bind.
module strrep_ctrl_chk #(
    parameter int CW = 16,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [2:0]    op_kind,
    input logic [1:0]    rep_kind,
    input logic          word_mode,
    input logic          dir_down,
    input logic [CW-1:0] cnt_in,
    input logic [AW-1:0] si_in,
    input logic [AW-1:0] di_in,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] cnt_out,
    input logic [AW-1:0] si_out,
    input logic [AW-1:0] di_out,
    input logic          req,
    input logic [2:0]    req_op,
    input logic          req_word,
    input logic [AW-1:0] req_si,
    input logic [AW-1:0] req_di,
    input logic          ack,
    input logic          zf_in
);
    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(req_si) && $stable(req_di)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && req));

    assert_no_req_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (cnt_out != '0));

    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> (cnt_out == $past(cnt_out) - CW'(1)));

    assert_load_keeps_di_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && req_op == 3'd1) |=> (di_out == $past(di_out)));

    assert_store_keeps_si_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && (req_op == 3'd2 || req_op == 3'd4)) |=> (si_out == $past(si_out)));
endmodule

bind strrep_ctrl strrep_ctrl_chk #(.CW(CW), .AW(AW)) u_chk (.*);

// File: tb/strrep_ctrl_test.sv
module strrep_ctrl_test;
    localparam int CW = 16;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op_kind = '0;
    logic [1:0] rep_kind = '0;
    logic word_mode = 1'b0, dir_down = 1'b0;
    logic [CW-1:0] cnt_in = '0;
    logic [AW-1:0] si_in = '0, di_in = '0;
    logic busy, done, req, req_word;
    logic [CW-1:0] cnt_out;
    logic [AW-1:0] si_out, di_out, req_si, req_di;
    logic [2:0] req_op;
    logic ack = 1'b0, zf_in = 1'b0;

    int n_tests = 0;
    int n_fail = 0;
    int unsigned seed_dummy;

    always #2.5 clk = ~clk;

    strrep_ctrl #(.CW(CW), .AW(AW)) uut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit f_uses_si(input logic [2:0] op);
        return op == 3'd0 || op == 3'd1 || op == 3'd3;
    endfunction

    function automatic bit f_uses_di(input logic [2:0] op);
        return op == 3'd0 || op == 3'd2 || op == 3'd3 || op == 3'd4;
    endfunction

    function automatic bit f_cond(input logic [2:0] op, input logic [1:0] rule);
        return (op == 3'd3 || op == 3'd4) && (rule == 2'd1 || rule == 2'd2);
    endfunction

    // Expected number of elements performed
    function automatic int f_steps(input logic [2:0] op, input logic [1:0] rule,
                                   input int cnt, input int brk);
        if (f_cond(op, rule) && brk < cnt) return brk + 1;
        return cnt;
    endfunction

    function automatic logic [AW-1:0] f_final(input logic [AW-1:0] start_idx, input bit used,
                                              input bit word, input bit down, input int n);
        int d;
        d = used ? n * (word ? 2 : 1) : 0;
        return down ? start_idx - AW'(d) : start_idx + AW'(d);
    endfunction

    // One complete run; brk = element index receiving the breaking flag
    task automatic run_case(input logic [2:0] op, input logic [1:0] rule, input bit word,
                            input bit down, input int cnt, input logic [AW-1:0] si0,
                            input logic [AW-1:0] di0, input int brk, input bit poke);
        logic [AW-1:0] m_si, m_di;
        int steps, guard, exp_n, pulses;
        bit brk_val, seen_done, addr_ok, hold_ok;
        brk_val = (rule == 2'd1) ? 1'b0 : (rule == 2'd2) ? 1'b1 : 1'($urandom % 2);
        exp_n = f_steps(op, rule, cnt, brk);
        m_si = si0; m_di = di0; steps = 0; guard = 0; seen_done = 0;
        addr_ok = 1; hold_ok = 1;
        @(negedge clk);
        start = 1; op_kind = op; rep_kind = rule; word_mode = word; dir_down = down;
        cnt_in = CW'(cnt); si_in = si0; di_in = di0;
        @(negedge clk);
        start = 0; op_kind = 3'd7; cnt_in = 16'hAAAA; si_in = 16'h5555; di_in = 16'h3333;
        while (!seen_done && guard < 2000) begin
            guard++;
            if (done) begin
                seen_done = 1;
            end else if (req) begin
                if (req_si !== m_si || req_di !== m_di) addr_ok = 0;
                if (steps == 0) begin
                    check(req_op == op && req_word == word, "R11 req_op/req_word", int'(req_op), int'(op));
                    if (poke) begin
                        start = 1; cnt_in = 16'd99;
                    end
                end
                for (int w = $urandom % 3; w > 0; w--) begin
                    @(negedge clk);
                    start = 0;
                    if (!req || req_si !== m_si || req_di !== m_di) hold_ok = 0;
                end
                ack = 1;
                zf_in = (steps == brk) ? brk_val : ~brk_val;
                @(negedge clk);
                start = 0; ack = 0; zf_in = 0;
                steps++;
                if (f_uses_si(op)) m_si = down ? m_si - AW'(word ? 2 : 1) : m_si + AW'(word ? 2 : 1);
                if (f_uses_di(op)) m_di = down ? m_di - AW'(word ? 2 : 1) : m_di + AW'(word ? 2 : 1);
                continue;
            end
            if (!seen_done) @(negedge clk);
        end
        check(seen_done, "R10 done seen", int'(seen_done), 1);
        check(addr_ok, "R9 request indexes", int'(addr_ok), 1);
        check(hold_ok, "R9 request held", int'(hold_ok), 1);
        pulses = 0;
        @(negedge clk);
        if (done) pulses++;
        check(pulses == 0 && !busy, "R10 done single pulse", pulses, 0);
        check(steps == exp_n, cnt == 0 ? "R2 zero count steps" :
              f_cond(op, rule) ? (rule == 2'd1 ? "R4 steps" : "R5 steps") :
              (rule != 2'd0 ? "R8 steps" : "R3 steps"), steps, exp_n);
        check(int'(cnt_out) == cnt - exp_n, "R3 final count", int'(cnt_out), cnt - exp_n);
        check(si_out == f_final(si0, f_uses_si(op), word, down, exp_n), "R6 R7 final si",
              int'(si_out), int'(f_final(si0, f_uses_si(op), word, down, exp_n)));
        check(di_out == f_final(di0, f_uses_di(op), word, down, exp_n), "R6 R7 final di",
              int'(di_out), int'(f_final(di0, f_uses_di(op), word, down, exp_n)));
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++; n_tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !req, "R1 reset controls", int'({busy, done, req}), 0);
        check(cnt_out == 0 && si_out == 0 && di_out == 0, "R1 reset registers", int'(cnt_out), 0);
        // R2 zero count
        run_case(3'd0, 2'd0, 0, 0, 0, 16'h1000, 16'h2000, 99, 0);
        run_case(3'd3, 2'd1, 1, 1, 0, 16'h0010, 16'h0020, 0, 0);
        // R3 plain move, byte up; word down with wrap (R6)
        run_case(3'd0, 2'd0, 0, 0, 5, 16'h0100, 16'h0200, 99, 0);
        run_case(3'd0, 2'd0, 1, 1, 4, 16'h0002, 16'h0001, 99, 0);
        // R4 while-equal compare breaking at element 2; and running out
        run_case(3'd3, 2'd1, 0, 0, 6, 16'h0040, 16'h0080, 2, 0);
        run_case(3'd4, 2'd1, 1, 0, 3, 16'h0040, 16'h0080, 9, 0);
        // R5 while-not-equal scan breaking on first element; word down
        run_case(3'd4, 2'd2, 1, 1, 5, 16'h0300, 16'h0400, 0, 0);
        run_case(3'd3, 2'd2, 0, 1, 4, 16'h0300, 16'h0400, 3, 0);
        // R8 conditional rules on load and store ignore the flag
        run_case(3'd1, 2'd1, 0, 0, 4, 16'h0500, 16'h0600, 0, 0);
        run_case(3'd2, 2'd2, 1, 0, 3, 16'h0500, 16'h0600, 0, 0);
        // R10 start while busy ignored
        run_case(3'd0, 2'd0, 1, 0, 3, 16'h0700, 16'h0800, 99, 1);
        // Random mix (R6 R7)
        for (int k = 0; k < 40; k++) begin
            run_case(3'($urandom % 5), 2'($urandom % 3), 1'($urandom % 2), 1'($urandom % 2),
                     int'($urandom % 7), 16'($urandom), 16'($urandom), int'($urandom % 8),
                     1'($urandom % 2));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule